// File: doc/BRIEF.md
# Line Status Interrupt Register

The block gathers a vector of line condition flags from a physical-layer receiver into a single latched status word and raises one interrupt line for software. Each flag position is fixed as one of two kinds. Error positions latch whenever their condition is present, so every occurrence is caught. Alarm positions latch whenever their condition changes level, on both rising and falling transitions.

A per-bit enable word is held in a second register. Only latched bits whose enable is set can drive the interrupt output. A processor reads the status word over a simple synchronous bus, and that read clears the word. An event that lands in the same cycle as the clearing read is kept, so no condition is lost. The enable word can be written and read back at its own address.

Top module: `lsr_line_status_irq`

## Requirements
- R1: After reset, and while `rst_ni` is low, the status word, the enable word, `bus_rdata_o` and `irq_o` are all zero.
- R2: Bits 9 to 13 are error bits. In every cycle where `line_cond_i[k]` is 1 for such a bit, status bit k is 1 after that clock edge, even if a clearing read happens in the same cycle.
- R3: Every other bit (0 to 8 and 14 to 15) is an alarm bit. A rising transition of its input sets its status bit at the clock edge where the new level is sampled.
- R4: A falling transition of an alarm input also sets its status bit. An alarm input that holds its level sets nothing.
- R5: At the first clock edge after reset, the alarm inputs are only captured as the reference level. No alarm bit is set at that edge, whatever the input levels are.
- R6: `irq_o` is active-high and level-based. It is 1 exactly when some status bit and its enable bit are both 1, and it follows an enable write in the cycle after that write.
- R7: A write (`bus_wr_i`=1) to address 0x2D loads `bus_wdata_i` into the 16-bit enable word. A read of 0x2D returns that word.
- R8: A read (`bus_rd_i`=1) of address 0x38 puts the status word, as it was before the edge, on `bus_rdata_o` one cycle later, and clears every status bit that has no new event in that cycle.
- R9: An alarm transition arriving in the same cycle as a clearing read leaves its status bit set after the read.
- R10: A read of the enable address does not clear the status word. A read of any other address returns zero. A write to 0x38 has no effect on the status or on `irq_o`.
- R11: In cycles with no read, `bus_rdata_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_cond_i | input | 16 | Line condition flags; bits 9 to 13 are error bits, the rest are alarm bits |
| bus_addr_i | input | 8 | Register address: 0x38 is status, 0x2D is enable |
| bus_wr_i | input | 1 | Write strobe, one cycle |
| bus_wdata_i | input | 16 | Write data |
| bus_rd_i | input | 1 | Read strobe, one cycle |
| bus_rdata_o | output | 16 | Read data, valid the cycle after the strobe |
| irq_o | output | 1 | Interrupt, active high, level |

## Verification
A condition driven before a clock edge shows up in the status word at that same edge. `irq_o` is combinational from the status and enable registers, so it has also settled one time unit after that edge. Read data comes from a register loaded at the edge where the strobe is sampled, so it is also due right after that edge. Every vector is driven at the falling edge and compared 1 ns after the next rising edge, which is the first point where the one-edge latency of the status, the enable, the read data and the interrupt is visible. The reset checks are made while reset is still low, and again after a reset asserted in the middle of a run.

// File: rtl/lsr_pkg.sv
package lsr_pkg;
  localparam int unsigned STAT_W    = 16;
  localparam int unsigned ADDR_W    = 8;
  localparam int unsigned ERR_LO    = 9;
  localparam int unsigned ERR_HI    = 13;
  localparam logic [ADDR_W-1:0] STAT_ADDR = 8'h38;
  localparam logic [ADDR_W-1:0] EN_ADDR   = 8'h2D;

  function automatic logic [STAT_W-1:0] err_mask(input int unsigned lo, input int unsigned hi);
    logic [STAT_W-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < STAT_W; i++) m[i] = (i >= lo) && (i <= hi);
    return m;
  endfunction
endpackage

// File: rtl/lsr_event_detect.sv
module lsr_event_detect #(
  parameter int unsigned W      = lsr_pkg::STAT_W,
  parameter int unsigned ERR_LO = lsr_pkg::ERR_LO,
  parameter int unsigned ERR_HI = lsr_pkg::ERR_HI
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] cond_i,
  output logic [W-1:0] set_o
);
  logic primed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) primed_q <= 1'b0;
    else         primed_q <= 1'b1;
  end

  for (genvar k = 0; k < W; k++) begin : g_bit
    if ((k >= ERR_LO) && (k <= ERR_HI)) begin : g_err
      // every cycle the condition is present counts as an occurrence
      assign set_o[k] = cond_i[k];
    end else begin : g_alarm
      logic prev_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prev_q <= 1'b0;
        else         prev_q <= cond_i[k];
      end
      // first edge after reset only captures the reference level
      assign set_o[k] = primed_q & (cond_i[k] ^ prev_q);
    end
  end
endmodule

// File: rtl/lsr_status_bank.sv
module lsr_status_bank #(
  parameter int unsigned W = lsr_pkg::STAT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] status_o
);
  logic [W-1:0] status_q;

  // new events win over the clearing read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (clr_i ? '0 : status_q) | set_i;
  end

  assign status_o = status_q;
endmodule

// File: rtl/lsr_bus_regs.sv
module lsr_bus_regs #(
  parameter int unsigned           W         = lsr_pkg::STAT_W,
  parameter int unsigned           AW        = lsr_pkg::ADDR_W,
  parameter logic [AW-1:0]         STAT_ADDR = lsr_pkg::STAT_ADDR,
  parameter logic [AW-1:0]         EN_ADDR   = lsr_pkg::EN_ADDR
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          rd_i,
  input  logic [W-1:0]  status_i,
  output logic [W-1:0]  en_o,
  output logic [W-1:0]  rdata_o,
  output logic          clr_o
);
  logic [W-1:0] en_q;
  logic [W-1:0] rdata_q;
  logic [W-1:0] rsel;
  logic         hit_stat;
  logic         hit_en;

  assign hit_stat = (addr_i == STAT_ADDR);
  assign hit_en   = (addr_i == EN_ADDR);

  always_comb begin
    rsel = '0;
    if (hit_stat)    rsel = status_i;
    else if (hit_en) rsel = en_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= '0;
      rdata_q <= '0;
    end else begin
      if (wr_i && hit_en) en_q <= wdata_i;
      rdata_q <= rd_i ? rsel : '0;
    end
  end

  assign clr_o   = rd_i && hit_stat;
  assign en_o    = en_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/lsr_line_status_irq.sv
module lsr_line_status_irq #(
  parameter int unsigned STAT_W = lsr_pkg::STAT_W,
  parameter int unsigned ADDR_W = lsr_pkg::ADDR_W,
  parameter int unsigned ERR_LO = lsr_pkg::ERR_LO,
  parameter int unsigned ERR_HI = lsr_pkg::ERR_HI
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STAT_W-1:0] line_cond_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic [STAT_W-1:0] bus_wdata_i,
  input  logic              bus_rd_i,
  output logic [STAT_W-1:0] bus_rdata_o,
  output logic              irq_o
);
  logic [STAT_W-1:0] set_vec;
  logic [STAT_W-1:0] stat_vec;
  logic [STAT_W-1:0] en_vec;
  logic              clr;

  lsr_event_detect #(.W(STAT_W), .ERR_LO(ERR_LO), .ERR_HI(ERR_HI)) u_detect (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cond_i (line_cond_i),
    .set_o  (set_vec)
  );

  lsr_status_bank #(.W(STAT_W)) u_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (set_vec),
    .clr_i    (clr),
    .status_o (stat_vec)
  );

  lsr_bus_regs #(.W(STAT_W), .AW(ADDR_W)) u_bus (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (bus_addr_i),
    .wr_i     (bus_wr_i),
    .wdata_i  (bus_wdata_i),
    .rd_i     (bus_rd_i),
    .status_i (stat_vec),
    .en_o     (en_vec),
    .rdata_o  (bus_rdata_o),
    .clr_o    (clr)
  );

  assign irq_o = |(stat_vec & en_vec);
endmodule

// File: rtl/lsr_line_status_irq_chk.sv
module lsr_line_status_irq_chk #(
  parameter int unsigned STAT_W = lsr_pkg::STAT_W,
  parameter int unsigned ADDR_W = lsr_pkg::ADDR_W,
  parameter int unsigned ERR_LO = lsr_pkg::ERR_LO,
  parameter int unsigned ERR_HI = lsr_pkg::ERR_HI
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [STAT_W-1:0] line_cond_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic              bus_wr_i,
  input logic              bus_rd_i,
  input logic [STAT_W-1:0] bus_rdata_o,
  input logic              irq_o,
  input logic [STAT_W-1:0] stat_vec,
  input logic [STAT_W-1:0] en_vec
);
  localparam logic [STAT_W-1:0] ERR_M = lsr_pkg::err_mask(ERR_LO, ERR_HI);
  logic seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  for (genvar k = 0; k < STAT_W; k++) begin : g_chk
    if ((k >= ERR_LO) && (k <= ERR_HI)) begin : g_err
      p_err_latch_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        line_cond_i[k] |=> stat_vec[k]);
    end else begin : g_alarm
      p_alarm_edge_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seen_q && (line_cond_i[k] != $past(line_cond_i[k]))) |=> stat_vec[k]);
    end
  end

  p_rd_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && bus_rd_i && (bus_addr_i == lsr_pkg::STAT_ADDR) &&
     ((line_cond_i & ERR_M) == '0) && (line_cond_i == $past(line_cond_i)))
    |=> (stat_vec == '0));

  p_rd_data_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_i && (bus_addr_i == lsr_pkg::STAT_ADDR)) |=> (bus_rdata_o == $past(stat_vec)));

  p_en_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_wr_i && (bus_addr_i == lsr_pkg::EN_ADDR)) |=> $stable(en_vec));

  p_irq_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_vec == '0) |-> !irq_o);

  p_idle_rdata_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_rd_i |=> (bus_rdata_o == '0));
endmodule

bind lsr_line_status_irq lsr_line_status_irq_chk #(
  .STAT_W(STAT_W), .ADDR_W(ADDR_W), .ERR_LO(ERR_LO), .ERR_HI(ERR_HI)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .line_cond_i (line_cond_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wr_i    (bus_wr_i),
  .bus_rd_i    (bus_rd_i),
  .bus_rdata_o (bus_rdata_o),
  .irq_o       (irq_o),
  .stat_vec    (stat_vec),
  .en_vec      (en_vec)
);

// File: tb/tb_lsr_line_status_irq.sv
`timescale 1ns/1ps
module tb_lsr_line_status_irq;
  localparam int NV = 19;
  localparam logic [7:0] AS = 8'h38;
  localparam logic [7:0] AE = 8'h2D;

  // {cond16, wr, rd, addr8, wdata16, exp_rdata16, exp_irq}
  localparam logic [58:0] VEC [NV] = '{
    {16'h0001, 1'b0, 1'b0, 8'h00, 16'h0000, 16'h0000, 1'b0}, // 0 prime edge R5
    {16'h0001, 1'b0, 1'b1, AS,    16'h0000, 16'h0000, 1'b0}, // 1 steady level R5 R4
    {16'h0000, 1'b0, 1'b0, 8'h00, 16'h0000, 16'h0000, 1'b0}, // 2 fall bit0 R4 R11
    {16'h0000, 1'b1, 1'b0, AE,    16'h0201, 16'h0000, 1'b1}, // 3 enable R6 R7
    {16'h0000, 1'b0, 1'b1, AE,    16'h0000, 16'h0201, 1'b1}, // 4 enable read R7 R10
    {16'h0000, 1'b0, 1'b1, AS,    16'h0000, 16'h0001, 1'b0}, // 5 clear R8
    {16'h0200, 1'b0, 1'b0, 8'h00, 16'h0000, 16'h0000, 1'b1}, // 6 error R2
    {16'h0200, 1'b0, 1'b1, AS,    16'h0000, 16'h0200, 1'b1}, // 7 error during read R2
    {16'h0000, 1'b0, 1'b1, AS,    16'h0000, 16'h0200, 1'b0}, // 8 clear R8
    {16'h0000, 1'b0, 1'b1, AS,    16'h0000, 16'h0000, 1'b0}, // 9 empty R8
    {16'h0002, 1'b0, 1'b0, 8'h00, 16'h0000, 16'h0000, 1'b0}, // 10 rise bit1 R3
    {16'h0002, 1'b0, 1'b1, 8'h11, 16'h0000, 16'h0000, 1'b0}, // 11 other addr R10
    {16'h0002, 1'b1, 1'b0, AS,    16'hFFFF, 16'h0000, 1'b0}, // 12 write status R10
    {16'h0002, 1'b0, 1'b1, AS,    16'h0000, 16'h0002, 1'b0}, // 13 R3 R10
    {16'h0402, 1'b0, 1'b1, AS,    16'h0000, 16'h0000, 1'b0}, // 14 error with read R2
    {16'h0402, 1'b1, 1'b0, AE,    16'h0400, 16'h0000, 1'b1}, // 15 R6
    {16'h8402, 1'b0, 1'b1, AS,    16'h0000, 16'h0400, 1'b1}, // 16 rise bit15 with read R9
    {16'h0000, 1'b0, 1'b1, AS,    16'h0000, 16'h8400, 1'b0}, // 17 falls R4 R9
    {16'h0000, 1'b0, 1'b1, AS,    16'h0000, 16'h8002, 1'b0}  // 18 R8
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] line_cond_i = '0;
  logic [7:0]  bus_addr_i = '0;
  logic        bus_wr_i = 1'b0;
  logic [15:0] bus_wdata_i = '0;
  logic        bus_rd_i = 1'b0;
  logic [15:0] bus_rdata_o;
  logic        irq_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk_i = ~clk_i;

  lsr_line_status_irq dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .line_cond_i (line_cond_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wr_i    (bus_wr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rd_i    (bus_rd_i),
    .bus_rdata_o (bus_rdata_o),
    .irq_o       (irq_o)
  );

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic drive(input logic [15:0] c, input logic w, input logic r,
                       input logic [7:0] a, input logic [15:0] d);
    line_cond_i = c; bus_wr_i = w; bus_rd_i = r; bus_addr_i = a; bus_wdata_i = d;
  endtask

  task automatic step;
    @(posedge clk_i); #1;
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog got=hung exp=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 irq in reset", {15'b0, irq_o}, 16'h0);
    chk("R1 rdata in reset", bus_rdata_o, 16'h0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][58:43], VEC[i][42], VEC[i][41], VEC[i][40:33], VEC[i][32:17]);
      step();
      chk($sformatf("R8 vec%0d rdata", i), bus_rdata_o, VEC[i][16:1]);
      chk($sformatf("R6 vec%0d irq", i), {15'b0, irq_o}, {15'b0, VEC[i][0]});
      @(negedge clk_i);
    end

    // mid-run reset
    drive(16'h0200, 1'b1, 1'b0, AE, 16'hFFFF);
    step();
    chk("R6 irq before reset", {15'b0, irq_o}, 16'h1);
    @(negedge clk_i);
    drive(16'h0000, 1'b0, 1'b0, 8'h00, 16'h0000);
    rst_ni = 1'b0;
    #1;
    chk("R1 irq async reset", {15'b0, irq_o}, 16'h0);
    chk("R1 rdata async reset", bus_rdata_o, 16'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    drive(16'h8001, 1'b0, 1'b0, 8'h00, 16'h0000); // alarm high at prime edge
    step();
    @(negedge clk_i);
    drive(16'h8001, 1'b0, 1'b1, AE, 16'h0000);
    step();
    chk("R1 R7 enable cleared", bus_rdata_o, 16'h0000);
    @(negedge clk_i);
    drive(16'h8001, 1'b0, 1'b1, AS, 16'h0000);
    step();
    chk("R1 R5 status empty", bus_rdata_o, 16'h0000);
    @(negedge clk_i);
    drive(16'h8001, 1'b0, 1'b0, 8'h00, 16'h0000);
    step();
    chk("R11 idle rdata", bus_rdata_o, 16'h0000);
    @(negedge clk_i);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule